// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in a memory controller's command path and turns one column access into the sequence of column addresses for every beat of an SDRAM read or write burst. A start strobe captures the starting column, the programmed burst length code and the ordering (sequential or interleaved). From the next cycle on, the block presents one column per beat and moves to the next column on each cycle in which the advance input is high.

Fixed-length bursts of 1, 2, 4 and 8 beats keep the column bits above the burst block constant. Only the low bits walk, either by wrapping addition or by XOR with the beat index. A full-page burst walks all 512 columns of the row in sequential order and wraps from the last column back to the first. It ends only when stopped. A stop input ends a burst of any length at the current beat. A new start is accepted on any cycle and replaces a burst that is still in progress. A single-bit-write option forces write bursts to one beat while reads keep the programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: A cycle with start_i high loads a burst. From the next clock edge valid_o is 1 and col_o equals the col_i sampled with the start.
- R2: With order_i=0 (sequential), beat k shows the start column with its low log2(L) bits replaced by (start low bits + k) mod L. The bits above stay fixed. For example, L=4 from column 1 gives 1,2,3,0.
- R3: With order_i=1 (interleaved) and L of 2, 4 or 8, beat k shows the start column with its low log2(L) bits XORed with k. For example, L=8 from column 5 gives 5,4,7,6,1,0,3,2.
- R4: len_i selects the burst length. The codes are 0 for 1 beat, 1 for 2, 2 for 4, 3 for 8 and 7 for full page. The reserved codes 4, 5 and 6 give a 1-beat burst.
- R5: done_o is high during the last beat of a fixed-length burst. When advance is high in that beat, valid_o is 0 from the next edge.
- R6: A 1-beat burst shows only the start column, with done_o high in that same first beat.
- R7: A full-page burst (len_i=7) uses sequential order even when order_i=1. It steps through all 512 columns, wrapping from 511 to 0, and never raises done_o unless stop_i is high.
- R8: stop_i high during a valid beat raises done_o in that cycle. valid_o is 0 after the next edge, unless a start arrives in the same cycle.
- R9: A start during a running burst takes priority over stop_i and advance. The next cycle shows beat 0 of the new burst.
- R10: While adv_i is 0, a running burst holds its column and stays valid.
- R11: With single_wr_i=1, a write burst (wr_i=1) is one beat whatever len_i says. A read burst (wr_i=0) keeps the length given by len_i.
- R12: After reset, valid_o and done_o are 0 and col_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new burst |
| col_i | input | 9 | Starting column |
| len_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| wr_i | input | 1 | 1 for a write burst |
| single_wr_i | input | 1 | Force write bursts to one beat |
| adv_i | input | 1 | Step to the next beat |
| stop_i | input | 1 | Terminate the burst at the current beat |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| done_o | output | 1 | The current beat is the final one |

## Verification
Beat 0 appears one edge after the start cycle. Each later beat appears one edge after a cycle in which advance was high. done_o is combinational on the current beat and stop_i, so it is due within the same cycle. valid_o drops one edge after the final beat or the stop. The bench drives inputs on the falling edge and samples 1 ns later. Each sample therefore sees the registered beat from the preceding rising edge, together with the done_o that the freshly driven stop_i produces. The expected column lists and done positions come from the ordering rules, not from the design.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd7
  } len_code_e;

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;
endpackage

// File: rtl/bcg_cfg.sv
module bcg_cfg
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_i,
  input  logic             order_i,
  input  logic             wr_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] mask_q,
  output logic             full_q,
  output logic             intlv_q
);
  logic [COL_W-1:0] mask_d;
  logic             full_d;

  always_comb begin
    full_d = 1'b0;
    unique case (len_i)
      LEN_2:    mask_d = COL_W'(1);
      LEN_4:    mask_d = COL_W'(3);
      LEN_8:    mask_d = COL_W'(7);
      LEN_PAGE: begin mask_d = '1; full_d = 1'b1; end
      default:  mask_d = '0;  // 1 beat, reserved codes included
    endcase
    if (wr_i && single_wr_i) begin
      mask_d = '0;
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      intlv_q <= 1'b0;
    end else if (start_i) begin
      base_q  <= col_i;
      mask_q  <= mask_d;
      full_q  <= full_d;
      intlv_q <= (order_i == ORD_INTLV) && !full_d;
    end
  end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  input  logic             stop_i,
  input  logic             full_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] cnt_q,
  output logic             valid_q,
  output logic             done_o
);
  logic at_last;

  assign at_last = valid_q && !full_i && (cnt_q == mask_i);
  assign done_o  = valid_q && (at_last || stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      cnt_q   <= '0;
    end else if (valid_q) begin
      if (stop_i || (adv_i && at_last)) valid_q <= 1'b0;
      else if (adv_i)                   cnt_q   <= cnt_q + 1'b1;  // wraps for full page
    end
  end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             intlv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  assign sum = base_i + cnt_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    always_comb begin
      if (!mask_i[i])   col_o[i] = base_i[i];
      else if (intlv_i) col_o[i] = base_i[i] ^ cnt_i[i];
      else              col_o[i] = sum[i];
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_i,
  input  logic             order_i,
  input  logic             wr_i,
  input  logic             single_wr_i,
  input  logic             adv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             done_o
);
  logic [COL_W-1:0] base_q, mask_q, cnt_q;
  logic             full_q, intlv_q;

  bcg_cfg #(.COL_W(COL_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .col_i       (col_i),
    .len_i       (len_i),
    .order_i     (order_i),
    .wr_i        (wr_i),
    .single_wr_i (single_wr_i),
    .base_q      (base_q),
    .mask_q      (mask_q),
    .full_q      (full_q),
    .intlv_q     (intlv_q)
  );

  bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .adv_i   (adv_i),
    .stop_i  (stop_i),
    .full_i  (full_q),
    .mask_i  (mask_q),
    .cnt_q   (cnt_q),
    .valid_q (valid_o),
    .done_o  (done_o)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base_i  (base_q),
    .cnt_i   (cnt_q),
    .mask_i  (mask_q),
    .intlv_i (intlv_q),
    .col_o   (col_o)
  );
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
  parameter int COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic             adv_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             done_o,
  input logic [COL_W-1:0] mask_q,
  input logic             full_q
);
  assert_start_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(col_i)));

  assert_upper_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i && !done_o) |=>
      ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));

  assert_done_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);

  assert_done_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && adv_i && !start_i) |=> !valid_o);

  assert_page_no_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && full_q && !stop_i) |-> !done_o);

  assert_stop_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !adv_i && !start_i && !stop_i) |=> (valid_o && $stable(col_o)));
endmodule

bind burst_col_gen bcg_chk #(.COL_W(COL_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .col_i   (col_i),
  .adv_i   (adv_i),
  .stop_i  (stop_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .done_o  (done_o),
  .mask_q  (mask_q),
  .full_q  (full_q)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] col_i = '0;
  logic [2:0] len_i = '0;
  logic       order_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       single_wr_i = 1'b0;
  logic       adv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, done_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  burst_col_gen u0 (.*);

  // {beats[4], order, len[3], start[9], beat7 .. beat0}
  localparam int NV = 7;
  localparam logic [88:0] VEC [NV] = '{
    {4'd4, 1'b0, 3'd2, 9'h001, 9'h0, 9'h0, 9'h0, 9'h0, 9'h000, 9'h003, 9'h002, 9'h001},
    {4'd8, 1'b1, 3'd3, 9'h005, 9'h002, 9'h003, 9'h000, 9'h001, 9'h006, 9'h007, 9'h004, 9'h005},
    {4'd8, 1'b0, 3'd3, 9'h1F6, 9'h1F5, 9'h1F4, 9'h1F3, 9'h1F2, 9'h1F1, 9'h1F0, 9'h1F7, 9'h1F6},
    {4'd4, 1'b1, 3'd2, 9'h0A3, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0A0, 9'h0A1, 9'h0A2, 9'h0A3},
    {4'd2, 1'b0, 3'd1, 9'h0A3, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0A2, 9'h0A3},
    {4'd1, 1'b0, 3'd0, 9'h055, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h055},
    {4'd8, 1'b1, 3'd3, 9'h10E, 9'h109, 9'h108, 9'h10B, 9'h10A, 9'h10D, 9'h10C, 9'h10F, 9'h10E}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the next falling edge with beat 0 loaded
  task automatic launch(input logic [8:0] c, input logic [2:0] l, input logic o,
                        input logic w, input logic s);
    start_i = 1'b1; col_i = c; len_i = l; order_i = o; wr_i = w; single_wr_i = s;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk("R12 valid", valid_o, 0);
    chk("R12 done", done_o, 0);
    chk("R12 col", col_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: R2 R3 R6
    adv_i = 1'b1;
    for (int v = 0; v < NV; v++) begin
      automatic int n = int'(VEC[v][88:85]);
      launch(VEC[v][80:72], VEC[v][83:81], VEC[v][84], 1'b0, 1'b0);
      for (int b = 0; b < n; b++) begin
        #1;
        chk(VEC[v][84] ? "R3 col" : "R2 col", col_o, int'(VEC[v][b*9 +: 9]));
        chk(n == 1 ? "R6 done" : "R5 done", done_o, (b == n-1) ? 1 : 0);
        @(negedge clk_i);
      end
      #1;
      chk("R5 end", valid_o, 0);
      @(negedge clk_i);
    end

    // R7 full page, interleave request ignored, wrap past 511
    launch(9'h1FE, 3'd7, 1'b1, 1'b0, 1'b0);
    for (int b = 0; b < 520; b++) begin
      #1;
      chk("R7 col", col_o, (9'h1FE + b) & 9'h1FF);
      chk("R7 done", done_o, 0);
      @(negedge clk_i);
    end
    // R8 stop
    stop_i = 1'b1;
    #1;
    chk("R8 done", done_o, 1);
    chk("R8 col", col_o, (9'h1FE + 520) & 9'h1FF);
    @(negedge clk_i);
    stop_i = 1'b0;
    #1;
    chk("R8 end", valid_o, 0);
    @(negedge clk_i);

    // R10 hold
    adv_i = 1'b0;
    launch(9'h020, 3'd3, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R10 col", col_o, 9'h020);
      chk("R10 valid", valid_o, 1);
      @(negedge clk_i);
    end
    adv_i = 1'b1;
    @(negedge clk_i);
    #1;
    chk("R10 step", col_o, 9'h021);

    // R9 restart with stop also high
    stop_i = 1'b1;
    launch(9'h083, 3'd2, 1'b0, 1'b0, 1'b0);
    stop_i = 1'b0;
    #1;
    chk("R9 col0", col_o, 9'h083);
    chk("R9 valid", valid_o, 1);
    @(negedge clk_i);
    #1;
    chk("R9 col1", col_o, 9'h080);
    @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);

    // R11 single-bit write
    launch(9'h011, 3'd3, 1'b0, 1'b1, 1'b1);
    #1;
    chk("R11 wr col", col_o, 9'h011);
    chk("R11 wr done", done_o, 1);
    @(negedge clk_i);
    #1;
    chk("R11 wr end", valid_o, 0);
    @(negedge clk_i);
    launch(9'h011, 3'd3, 1'b0, 1'b0, 1'b1);
    for (int b = 0; b < 8; b++) begin
      #1;
      chk("R11 rd done", done_o, (b == 7) ? 1 : 0);
      @(negedge clk_i);
    end

    // R4 reserved code acts as one beat
    launch(9'h044, 3'd5, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R4 col", col_o, 9'h044);
    chk("R4 done", done_o, 1);
    @(negedge clk_i);
    #1;
    chk("R4 end", valid_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule